// File: doc/BRIEF.md
# Per-Slot Transmit Output Selector

This unit sits between a time-slot switch core and the transmit serializers. Every cycle that carries a transmit slot, it looks up that slot's programmed behaviour and puts out one of these: the switched byte, a byte supplied by the host, an idle code, a pseudo-random or quasi-random test byte, a fixed test byte, or nothing at all. The result leaves one cycle later with a drive enable for the slot and a one-bit-per-highway enable for external line drivers. Because the tristate decision is made per slot, several such units can share one output highway, each driving only its own slots.

Slot behaviours are held in a mode memory indexed by highway and slot. The host writes a pending copy at any time. The copy that is in use is refreshed from the pending copy only on a frame-start pulse, so the output never changes behaviour in the middle of a frame. The two test-pattern generators step only in the slots that use them, which keeps each bit sequence unbroken across slots and frames.

Top module: `osub_unit`

## Requirements
- R1: A slot in mode 0 (pass) outputs `in_data` on `out_byte` with `out_oe`=1, one clock after the input cycle.
- R2: A slot in mode 1 (host) outputs `host_byte`, mode 2 (idle) outputs `idle_byte`, and mode 5 (fixed) outputs `fixed_byte`, each with `out_oe`=1.
- R3: A slot in mode 3 outputs the next 8 bits of a 15-bit LFSR sequence. Each bit is the feedback `s[14]^s[13]` of the polynomial x^15+x^14+1, shifted in at bit 0. The first bit produced goes to bit 7 of the byte. The register is all ones after reset.
- R4: A slot in mode 4 outputs the next 8 bits of a 20-bit LFSR sequence with feedback `q[19]^q[16]` (x^20+x^17+1), in the same bit order, with the register all ones after reset. An output bit is forced to 1 whenever the previous 14 output bits were all 0.
- R5: The mode-4 output stream never contains more than 14 consecutive zero bits.
- R6: Modes 6 and 7 give high impedance: `out_oe`=0, `out_byte`=0 and `hwy_oe` all zero for that slot.
- R7: `hwy_oe` has at most one bit set. Bit `h` is set exactly when the output slot belongs to highway `h` and is driven.
- R8: Each pattern generator advances by 8 bits only in a valid slot whose mode selects it, and keeps its state otherwise, including across frame starts.
- R9: A mode write changes nothing until the next `frame_start` pulse. A write made in the same cycle as a `frame_start` takes effect only at the following `frame_start`.
- R10: After reset every slot is in mode 6, and `out_valid`, `out_oe`, `out_byte` and `hwy_oe` are zero.
- R11: `out_valid` follows `in_valid` one clock later. A cycle with `in_valid`=0 yields `out_valid`=0, `out_oe`=0 and `hwy_oe`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A slot is presented this cycle |
| in_hwy | input | HW | Transmit highway of the slot |
| in_slot | input | SW | Slot index within the frame |
| in_data | input | 8 | Switched byte from the core |
| frame_start | input | 1 | Frame boundary pulse; loads pending modes |
| cfg_we | input | 1 | Host mode write strobe |
| cfg_hwy | input | HW | Highway of the mode write |
| cfg_slot | input | SW | Slot of the mode write |
| cfg_mode | input | 3 | Mode code 0..7 |
| host_byte | input | 8 | Host substitution byte |
| idle_byte | input | 8 | Idle code |
| fixed_byte | input | 8 | Fixed test byte |
| out_valid | output | 1 | Output slot valid |
| out_byte | output | 8 | Byte to serialize |
| out_oe | output | 1 | Slot drive enable |
| out_hwy | output | HW | Highway of the output slot |
| hwy_oe | output | NUM_HWY | External driver enable per highway |

## Verification
A table of slots, each with its own mode, is run after one frame start. It covers pass-through data of 0x00, 0xA5 and 0xFF, including a slot on the last highway and the last slot index. This separates each substitution source from the switched data and from the others. Pattern slots are interleaved with pass slots on other highways: a generator that stepped on every slot, or stepped once per frame, would give bytes that differ from the bench's own sequence models. Slots sent before the first frame start, and a write that coincides with a frame start, show whether the mode memory updates at the right boundary. The reserved code, high-impedance slots and idle cycles confirm that the slot and highway enables stay low.

// File: rtl/osub_pkg.sv
// Shared definitions for the per-slot output selector.
// Assumes mode codes are 3 bits wide; codes 6 and 7 both mean high impedance.
package osub_pkg;

    typedef enum logic [2:0] {
        M_PASS  = 3'd0,
        M_HOST  = 3'd1,
        M_IDLE  = 3'd2,
        M_PRBS  = 3'd3,
        M_QRSS  = 3'd4,
        M_FIXED = 3'd5,
        M_HIZ   = 3'd6,
        M_RSVD  = 3'd7
    } slot_mode_e;

    localparam int PAT_PRBS = 0;
    localparam int PAT_QRSS = 1;

    localparam logic [2:0] MODE_RESET = 3'd6;

endpackage

// File: rtl/osub_mode_mem.sv
// Double-copy slot mode memory.
// The host writes a pending copy; frame_start loads the whole active copy at once.
// A write landing on the same edge as frame_start reaches the active copy one frame later.
// Assumes NUM_HWY*SLOTS is at least 2. Out-of-range reads return high impedance.
module osub_mode_mem
    import osub_pkg::*;
#(
    parameter int NUM_HWY = 4,
    parameter int SLOTS   = 32,
    localparam int HW     = (NUM_HWY > 1) ? $clog2(NUM_HWY) : 1,
    localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int DEPTH  = NUM_HWY * SLOTS,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [HW-1:0] wr_hwy,
    input  logic [SW-1:0] wr_slot,
    input  logic [2:0]    wr_mode,
    input  logic          frame_start,
    input  logic [HW-1:0] rd_hwy,
    input  logic [SW-1:0] rd_slot,
    output logic [2:0]    rd_mode
);

    logic [2:0]    pend [DEPTH];
    logic [2:0]    act  [DEPTH];
    logic [AW-1:0] widx;
    logic [AW-1:0] ridx;
    logic          wr_ok;
    logic          rd_ok;

    // Flat addresses and range checks for the two ports.
    assign widx  = AW'(int'(wr_hwy) * SLOTS + int'(wr_slot));
    assign ridx  = AW'(int'(rd_hwy) * SLOTS + int'(rd_slot));
    assign wr_ok = (int'(wr_hwy) < NUM_HWY) && (int'(wr_slot) < SLOTS);
    assign rd_ok = (int'(rd_hwy) < NUM_HWY) && (int'(rd_slot) < SLOTS);

    // Pending copy: takes host writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pend[i] <= MODE_RESET;
        end else if (wr_en && wr_ok) begin
            pend[widx] <= wr_mode;
        end
    end

    // Active copy: reloaded from the pending copy at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) act[i] <= MODE_RESET;
        end else if (frame_start) begin
            for (int i = 0; i < DEPTH; i++) act[i] <= pend[i];
        end
    end

    // Read port used by the selector in the slot's own cycle.
    assign rd_mode = rd_ok ? act[ridx] : MODE_RESET;

    // R9: the active modes hold still between frame boundaries.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        a_r9_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_start |=> $stable(act[g]));
    end

endmodule

// File: rtl/osub_pattern_gen.sv
// Test-pattern byte source.
// KIND selects a 15-bit LFSR (x^15+x^14+1) or a 20-bit LFSR (x^20+x^17+1)
// with zero-run suppression. It produces 8 bits per step, first bit in bit 7.
// The state moves only when adv is high, so the sequence is unbroken across slots.
module osub_pattern_gen
    import osub_pkg::*;
#(
    parameter int KIND = PAT_PRBS,
    localparam int LEN  = (KIND == PAT_QRSS) ? 20 : 15,
    localparam int TAPB = (KIND == PAT_QRSS) ? 16 : 13,
    localparam int ZMAX = 14,
    localparam int ZRW  = 5,
    localparam bit SUPPRESS = (KIND == PAT_QRSS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    output logic [7:0] pat_byte
);

    logic [LEN-1:0] state;
    logic [LEN-1:0] st;
    logic [ZRW-1:0] zrun;
    logic [ZRW-1:0] zr;
    logic           nb;
    logic           ob;

    // Unroll eight LFSR steps to form the next byte and the state after it.
    always_comb begin
        st       = state;
        zr       = zrun;
        nb       = 1'b0;
        ob       = 1'b0;
        pat_byte = '0;
        for (int k = 0; k < 8; k++) begin
            nb = st[LEN-1] ^ st[TAPB];
            st = {st[LEN-2:0], nb};
            ob = (SUPPRESS && (zr == ZRW'(ZMAX))) ? 1'b1 : nb;
            zr = ob ? '0 : ((zr == '1) ? zr : zr + 1'b1);
            pat_byte[7-k] = ob;
        end
    end

    // Step the generator only in slots that select it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '1;
            zrun  <= '0;
        end else if (adv) begin
            state <= st;
            zrun  <= zr;
        end
    end

    // R8: no step without a selecting slot.
    a_r8_gen_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(state) && $stable(zrun)));

    if (SUPPRESS) begin : g_run_cap
        // R5: the zero run seen by the output never passes the limit.
        a_r5_zero_run_cap: assert property (@(posedge clk) disable iff (!rst_n)
            zrun <= ZRW'(ZMAX));
    end

endmodule

// File: rtl/osub_unit.sv
// Per-slot transmit output selector (top).
// For each valid slot it looks up the active mode and picks the switched byte,
// a substitute byte, a pattern byte or high impedance. The result is registered
// once, together with the slot drive enable and a per-highway driver enable.
// Assumes at most one slot per cycle and frame_start pulses between frames.
module osub_unit
    import osub_pkg::*;
#(
    parameter int NUM_HWY = 4,
    parameter int SLOTS   = 32,
    localparam int HW     = (NUM_HWY > 1) ? $clog2(NUM_HWY) : 1,
    localparam int SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [HW-1:0]      in_hwy,
    input  logic [SW-1:0]      in_slot,
    input  logic [7:0]         in_data,
    input  logic               frame_start,
    input  logic               cfg_we,
    input  logic [HW-1:0]      cfg_hwy,
    input  logic [SW-1:0]      cfg_slot,
    input  logic [2:0]         cfg_mode,
    input  logic [7:0]         host_byte,
    input  logic [7:0]         idle_byte,
    input  logic [7:0]         fixed_byte,
    output logic               out_valid,
    output logic [7:0]         out_byte,
    output logic               out_oe,
    output logic [HW-1:0]      out_hwy,
    output logic [NUM_HWY-1:0] hwy_oe
);

    logic [2:0]         cur_mode;
    logic [7:0]         prbs_byte;
    logic [7:0]         qrss_byte;
    logic [7:0]         pick;
    logic               drive;
    logic               adv_prbs;
    logic               adv_qrss;
    logic [NUM_HWY-1:0] oe_next;

    osub_mode_mem #(
        .NUM_HWY (NUM_HWY),
        .SLOTS   (SLOTS)
    ) u_mem (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_hwy      (cfg_hwy),
        .wr_slot     (cfg_slot),
        .wr_mode     (cfg_mode),
        .frame_start (frame_start),
        .rd_hwy      (in_hwy),
        .rd_slot     (in_slot),
        .rd_mode     (cur_mode)
    );

    // Generator steps are tied to valid slots of the matching mode.
    assign adv_prbs = in_valid && (cur_mode == M_PRBS);
    assign adv_qrss = in_valid && (cur_mode == M_QRSS);

    osub_pattern_gen #(.KIND(PAT_PRBS)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv_prbs),
        .pat_byte (prbs_byte)
    );

    osub_pattern_gen #(.KIND(PAT_QRSS)) u_qrss (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv_qrss),
        .pat_byte (qrss_byte)
    );

    // Decode the slot mode into a byte source and a drive decision.
    always_comb begin
        drive = 1'b1;
        pick  = in_data;
        case (slot_mode_e'(cur_mode))
            M_PASS:  pick = in_data;
            M_HOST:  pick = host_byte;
            M_IDLE:  pick = idle_byte;
            M_PRBS:  pick = prbs_byte;
            M_QRSS:  pick = qrss_byte;
            M_FIXED: pick = fixed_byte;
            default: begin
                drive = 1'b0;
                pick  = '0;
            end
        endcase
    end

    // Per-highway enable: only the slot's own highway, only when it drives.
    for (genvar h = 0; h < NUM_HWY; h++) begin : g_hoe
        assign oe_next[h] = in_valid && drive && (in_hwy == HW'(h));
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_oe    <= 1'b0;
            out_byte  <= '0;
            out_hwy   <= '0;
            hwy_oe    <= '0;
        end else begin
            out_valid <= in_valid;
            out_oe    <= in_valid && drive;
            out_byte  <= (in_valid && drive) ? pick : 8'h00;
            out_hwy   <= in_hwy;
            hwy_oe    <= oe_next;
        end
    end

    // R7: never more than one highway driver enabled.
    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hwy_oe));

    // R7: a driven slot enables its own highway.
    a_r7_own_highway: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_oe) |-> hwy_oe[out_hwy]);

    // R6: a silent slot puts nothing on the line.
    a_r6_hiz_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_oe) |-> ((out_byte == 8'h00) && (hwy_oe == '0)));

    // R11: no enable without a valid slot.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_oe && (hwy_oe == '0)));

endmodule

// File: tb/osub_unit_tb.sv
module osub_unit_tb;

    localparam int NH = 4;
    localparam int NS = 32;
    localparam logic [7:0] HOSTB  = 8'hC3;
    localparam logic [7:0] IDLEB  = 8'h7E;
    localparam logic [7:0] FIXEDB = 8'h5A;
    localparam int NV = 14;

    // {hwy, slot, mode, data}
    localparam logic [17:0] VEC [NV] = '{
        {2'd0, 5'd0,  3'd0, 8'hA5},
        {2'd3, 5'd31, 3'd0, 8'h00},
        {2'd1, 5'd2,  3'd1, 8'h11},
        {2'd2, 5'd5,  3'd2, 8'h22},
        {2'd0, 5'd7,  3'd5, 8'h33},
        {2'd1, 5'd8,  3'd3, 8'h44},
        {2'd2, 5'd9,  3'd3, 8'h55},
        {2'd3, 5'd10, 3'd4, 8'h66},
        {2'd0, 5'd11, 3'd4, 8'h77},
        {2'd1, 5'd12, 3'd6, 8'h88},
        {2'd2, 5'd13, 3'd7, 8'h99},
        {2'd3, 5'd14, 3'd3, 8'hFF},
        {2'd0, 5'd15, 3'd0, 8'hFF},
        {2'd1, 5'd16, 3'd4, 8'h01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_hwy = '0;
    logic [4:0] in_slot = '0;
    logic [7:0] in_data = '0;
    logic frame_start = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_hwy = '0;
    logic [4:0] cfg_slot = '0;
    logic [2:0] cfg_mode = '0;
    logic out_valid;
    logic [7:0] out_byte;
    logic out_oe;
    logic [1:0] out_hwy;
    logic [NH-1:0] hwy_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench sequence models
    logic [14:0] m_prbs;
    logic [19:0] m_qrss;
    int m_qz;

    always #2 clk = ~clk;

    osub_unit #(.NUM_HWY(NH), .SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hwy(in_hwy),
        .in_slot(in_slot), .in_data(in_data), .frame_start(frame_start),
        .cfg_we(cfg_we), .cfg_hwy(cfg_hwy), .cfg_slot(cfg_slot), .cfg_mode(cfg_mode),
        .host_byte(HOSTB), .idle_byte(IDLEB), .fixed_byte(FIXEDB),
        .out_valid(out_valid), .out_byte(out_byte), .out_oe(out_oe),
        .out_hwy(out_hwy), .hwy_oe(hwy_oe)
    );

    function automatic logic [7:0] prbs_step();
        logic [7:0] b;
        logic f;
        for (int k = 7; k >= 0; k--) begin
            f = m_prbs[14] ^ m_prbs[13];
            m_prbs = {m_prbs[13:0], f};
            b[k] = f;
        end
        return b;
    endfunction

    function automatic logic [7:0] qrss_step();
        logic [7:0] b;
        logic f;
        for (int k = 7; k >= 0; k--) begin
            f = m_qrss[19] ^ m_qrss[16];
            m_qrss = {m_qrss[18:0], f};
            if (m_qz >= 14) f = 1'b1;
            m_qz = f ? 0 : m_qz + 1;
            b[k] = f;
        end
        return b;
    endfunction

    // Expected {oe, byte} for a mode; advances the models as the requirements say.
    function automatic logic [8:0] expect_for(logic [2:0] mode, logic [7:0] d);
        case (mode)
            3'd0: return {1'b1, d};
            3'd1: return {1'b1, HOSTB};
            3'd2: return {1'b1, IDLEB};
            3'd3: return {1'b1, prbs_step()};
            3'd4: return {1'b1, qrss_step()};
            3'd5: return {1'b1, FIXEDB};
            default: return {1'b0, 8'h00};
        endcase
    endfunction

    task automatic check(string req, bit e_valid, bit e_oe, logic [7:0] e_byte, int h);
        logic [NH-1:0] e_hoe;
        e_hoe = (e_valid && e_oe) ? NH'(1 << h) : '0;
        total++;
        if (out_valid !== e_valid || out_oe !== e_oe || out_byte !== e_byte || hwy_oe !== e_hoe) begin
            bad++;
            $display("FAIL %s: got valid=%0b oe=%0b byte=%02h hoe=%b, want valid=%0b oe=%0b byte=%02h hoe=%b",
                     req, out_valid, out_oe, out_byte, hwy_oe, e_valid, e_oe, e_byte, e_hoe);
        end
    endtask

    // Present one slot at a falling edge; outputs are checked at the next falling edge.
    task automatic send(string req, logic [1:0] h, logic [4:0] s, logic [7:0] d, bit e_oe, logic [7:0] e_byte);
        in_valid = 1'b1; in_hwy = h; in_slot = s; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, 1'b1, e_oe, e_byte, int'(h));
    endtask

    task automatic send_vec(string req, int i);
        logic [8:0] e;
        e = expect_for(VEC[i][10:8], VEC[i][7:0]);
        send(req, VEC[i][17:16], VEC[i][15:11], VEC[i][7:0], e[8], e[7:0]);
    endtask

    task automatic write_mode(logic [1:0] h, logic [4:0] s, logic [2:0] m, bit with_frame);
        cfg_we = 1'b1; cfg_hwy = h; cfg_slot = s; cfg_mode = m; frame_start = with_frame;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running, want finished");
            report();
        end
    end

    initial begin
        m_prbs = '1; m_qrss = '1; m_qz = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: outputs zero out of reset
        check("R10 reset outputs", 1'b0, 1'b0, 8'h00, 0);
        // R10: unconfigured slot is high impedance
        send("R10 default hiz", 2'd1, 5'd3, 8'hEE, 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) write_mode(VEC[i][17:16], VEC[i][15:11], VEC[i][10:8], 1'b0);
        // R9: written but no frame boundary yet
        send("R9 before frame", 2'd0, 5'd0, 8'hA5, 1'b0, 8'h00);
        frame();

        // Table walk: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) send_vec($sformatf("R1-table/%0d R7", i), i);
        // second pass of the table: patterns continue, R3 R4
        for (int i = 0; i < NV; i++) send_vec($sformatf("R3 R4 pass2/%0d", i), i);

        // R8: pass slots between pattern slots, frame start, then patterns resume
        send("R8 pass filler", 2'd0, 5'd0, 8'h3C, 1'b1, 8'h3C);
        send("R8 pass filler", 2'd3, 5'd31, 8'hC3, 1'b1, 8'hC3);
        frame();
        send_vec("R8 prbs continues", 5);
        send_vec("R8 qrss continues", 7);
        frame();
        frame();
        send_vec("R8 prbs after frames", 6);
        send_vec("R8 qrss after frames", 13);

        // R11: empty cycle
        @(negedge clk);
        check("R11 idle cycle", 1'b0, 1'b0, 8'h00, 0);

        // R9: write coinciding with frame start waits one more frame
        write_mode(2'd0, 5'd0, 3'd2, 1'b1);
        send("R9 same-cycle write pending", 2'd0, 5'd0, 8'h5D, 1'b1, 8'h5D);
        frame();
        send("R9 same-cycle write applied", 2'd0, 5'd0, 8'h5D, 1'b1, IDLEB);

        // R6: reserved code 7 and code 6 on a previously driven slot
        write_mode(2'd3, 5'd31, 3'd7, 1'b0);
        send("R9 old mode kept", 2'd3, 5'd31, 8'h81, 1'b1, 8'h81);
        frame();
        send("R6 code7 hiz", 2'd3, 5'd31, 8'h81, 1'b0, 8'h00);

        // R5: run the QRSS slot for many bytes
        for (int n = 0; n < 300; n++) send_vec("R5 R4 qrss run", 8);

        done = 1'b1;
        report();
    end

endmodule